// File: doc/BRIEF.md
# Receive Output Fault Conditioning Selector

This block sits on the serial path between a DS3/E3 receive framer and the receive data output pin. On each bit (qualified by a bit-clock enable) it chooses what the output pin carries: the recovered line data, a steady stream of ones, or an alarm indication signal (AIS) pattern. The choice comes from software-held control bits and from the framer's live fault flags: loss of signal, out of frame, AIS detected and idle detected. The recovered data keeps feeding the receiver path in every mode, so the fault flags stay valid while an override is active.

The block also drives a sync marker next to the data. One control bit selects the marker style. In one style the marker flags every overhead bit position. In the other it flags only the first bit of each frame. Data and marker both pass through one register stage, so the latency is one bit for every selection.

Top module: `rx_fault_cond`

## Requirements
- R1: While reset is active, and after it until the first enabled bit, outData and outMark are both 0.
- R2: Outputs change only on a clock edge where bitEn is 1, and then show the selection for the inputs sampled at that edge (one bit of latency). With bitEn at 0 they hold.
- R3: With forceOnes, forceAis and autoOnesEn all 0, outData equals the sampled rxData.
- R4: forceOnes=1 makes outData 1 whatever the other inputs are.
- R5: With forceAis=1 and forceOnes=0, outData carries a 1,0,1,0,... pattern. The bit at which frameStart=1 is 1, and the pattern restarts there. It behaves the same for e3Mode 0 and 1.
- R6: With forceOnes=1 and forceAis=1 together, outData is 1.
- R7: With autoOnesEn=1, e3Mode=0 and neither force bit set, any of losFlag, oofFlag, aisFlag or idleFlag makes outData 1.
- R8: With autoOnesEn=1, e3Mode=1 and neither force bit set, losFlag, oofFlag or aisFlag makes outData 1. idleFlag alone has no effect, and outData equals rxData.
- R9: Automatic ones ends on the first bit at which no triggering flag is set, and outData follows rxData again. With autoOnesEn=0 the fault flags have no effect.
- R10: forceAis takes precedence over automatic ones: with faults present and autoOnesEn=1, outData still carries the AIS pattern.
- R11: With ovhMarkMode=1, outMark equals the sampled ovhBit.
- R12: With ovhMarkMode=0, outMark equals the sampled frameStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-clock enable; one bit per enabled edge |
| rxData | input | 1 | Recovered serial data |
| frameStart | input | 1 | High on the first bit of a frame |
| ovhBit | input | 1 | High on overhead bit positions |
| losFlag | input | 1 | Loss of signal status |
| oofFlag | input | 1 | Out of frame status |
| aisFlag | input | 1 | AIS detected status |
| idleFlag | input | 1 | Idle detected status |
| forceOnes | input | 1 | Force all ones onto the output |
| forceAis | input | 1 | Force the AIS pattern onto the output |
| autoOnesEn | input | 1 | Enable fault-triggered all ones |
| e3Mode | input | 1 | 1 = E3 rules, 0 = DS3 rules |
| ovhMarkMode | input | 1 | 1 = marker on overhead bits, 0 = marker on frame starts |
| outData | output | 1 | Conditioned serial data |
| outMark | output | 1 | Sync marker |

## Verification
The assertions assume that every input is settled and known at each clock edge, and that each check compares only the bits of a single enabled edge. They do not assume that frameStart recurs at any fixed spacing. The bench changes inputs only at the falling edge. It places frameStart at random, so the AIS phase model is exercised with frames of any length. Control bits and fault flags are drawn in weighted blocks, so that every priority level and both mode rules appear, and bitEn is left low often enough to test holding.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    SRC_LINE = 2'd0,
    SRC_ONES = 2'd1,
    SRC_AIS  = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    advance;   // take one bit this edge
    srcSel_e src;       // which stream feeds outData
    logic    markOvh;   // marker follows overhead flag
    logic    restart;   // frame start: realign AIS pattern
  } condCtrl_t;

endpackage

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
(
  input  logic      bitEn,
  input  logic      frameStart,
  input  logic      losFlag,
  input  logic      oofFlag,
  input  logic      aisFlag,
  input  logic      idleFlag,
  input  logic      forceOnes,
  input  logic      forceAis,
  input  logic      autoOnesEn,
  input  logic      e3Mode,
  input  logic      ovhMarkMode,
  output condCtrl_t ctl
);

  logic idleCounts;
  logic faultSeen;
  logic autoTrip;

  // idle is a trigger only under DS3 rules
  assign idleCounts = idleFlag & ~e3Mode;
  assign faultSeen  = losFlag | oofFlag | aisFlag | idleCounts;
  assign autoTrip   = autoOnesEn & faultSeen;

  always_comb begin
    ctl.advance = bitEn;
    ctl.markOvh = ovhMarkMode;
    ctl.restart = frameStart;
    if (forceOnes)      ctl.src = SRC_ONES;
    else if (forceAis)  ctl.src = SRC_AIS;
    else if (autoTrip)  ctl.src = SRC_ONES;
    else                ctl.src = SRC_LINE;
  end

endmodule

// File: rtl/rfc_dpath.sv
module rfc_dpath
  import rfc_pkg::*;
#(
  parameter int              PAT_LEN  = 4,
  parameter logic [PAT_LEN-1:0] PAT_BITS = 4'b1010
) (
  input  logic      clk,
  input  logic      rstN,
  input  condCtrl_t ctl,
  input  logic      rxData,
  input  logic      frameStart,
  input  logic      ovhBit,
  output logic      outData,
  output logic      outMark
);

  localparam int IDX_W = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_NEXT = IDX_W'(1);

  logic [IDX_W-1:0] patIdx;
  logic             patBit;
  logic             dataNext;
  logic             markNext;

  // pattern bit; the frame start bit always takes slot 0 (MSB)
  assign patBit = ctl.restart ? PAT_BITS[PAT_LEN-1]
                              : PAT_BITS[PAT_LEN-1-int'(patIdx)];

  always_comb begin
    unique case (ctl.src)
      SRC_ONES: dataNext = 1'b1;
      SRC_AIS:  dataNext = patBit;
      default:  dataNext = rxData;
    endcase
  end

  assign markNext = ctl.markOvh ? ovhBit : frameStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patIdx <= '0;
    end else if (ctl.advance) begin
      if (ctl.restart)            patIdx <= IDX_NEXT;
      else if (patIdx == IDX_LAST) patIdx <= '0;
      else                        patIdx <= patIdx + IDX_NEXT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= 1'b0;
      outMark <= 1'b0;
    end else if (ctl.advance) begin
      outData <= dataNext;
      outMark <= markNext;
    end
  end

  // R4
  ones_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && ctl.src == SRC_ONES) |=> outData);

  // R5
  ais_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && ctl.src == SRC_AIS && ctl.restart) |=> outData == PAT_BITS[PAT_LEN-1]);

endmodule

// File: rtl/rx_fault_cond.sv
module rx_fault_cond
  import rfc_pkg::*;
#(
  parameter int                 PAT_LEN  = 4,
  parameter logic [PAT_LEN-1:0] PAT_BITS = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic rxData,
  input  logic frameStart,
  input  logic ovhBit,
  input  logic losFlag,
  input  logic oofFlag,
  input  logic aisFlag,
  input  logic idleFlag,
  input  logic forceOnes,
  input  logic forceAis,
  input  logic autoOnesEn,
  input  logic e3Mode,
  input  logic ovhMarkMode,
  output logic outData,
  output logic outMark
);

  condCtrl_t ctl;

  rfc_ctrl u_ctrl (
    .bitEn       (bitEn),
    .frameStart  (frameStart),
    .losFlag     (losFlag),
    .oofFlag     (oofFlag),
    .aisFlag     (aisFlag),
    .idleFlag    (idleFlag),
    .forceOnes   (forceOnes),
    .forceAis    (forceAis),
    .autoOnesEn  (autoOnesEn),
    .e3Mode      (e3Mode),
    .ovhMarkMode (ovhMarkMode),
    .ctl         (ctl)
  );

  rfc_dpath #(
    .PAT_LEN  (PAT_LEN),
    .PAT_BITS (PAT_BITS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .rxData     (rxData),
    .frameStart (frameStart),
    .ovhBit     (ovhBit),
    .outData    (outData),
    .outMark    (outMark)
  );

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(outData) && $stable(outMark)));

  // R3
  pass_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !forceOnes && !forceAis && !autoOnesEn) |=> outData == $past(rxData));

  // R6
  both_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && forceOnes && forceAis) |=> outData);

  // R8
  e3_idle_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !forceOnes && !forceAis && e3Mode && !losFlag && !oofFlag && !aisFlag)
      |=> outData == $past(rxData));

  // R7
  ds3_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !forceOnes && !forceAis && autoOnesEn && !e3Mode &&
     (losFlag || oofFlag || aisFlag || idleFlag)) |=> outData);

  // R11
  mark_ovh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && ovhMarkMode) |=> outMark == $past(ovhBit));

  // R12
  mark_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !ovhMarkMode) |=> outMark == $past(frameStart));

endmodule

// File: tb/rx_fault_cond_bench.sv
`timescale 1ns/1ps
module rx_fault_cond_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 0, rxData = 0, frameStart = 0, ovhBit = 0;
  logic losFlag = 0, oofFlag = 0, aisFlag = 0, idleFlag = 0;
  logic forceOnes = 0, forceAis = 0, autoOnesEn = 0, e3Mode = 0, ovhMarkMode = 0;
  logic outData, outMark;

  int vecCount = 0;
  int failCount = 0;
  int bitPos = 0;          // bits since last frame start (model)
  logic expData = 1'b0;
  logic expMark = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_fault_cond u_rx_fault_cond (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxData(rxData),
    .frameStart(frameStart), .ovhBit(ovhBit), .losFlag(losFlag),
    .oofFlag(oofFlag), .aisFlag(aisFlag), .idleFlag(idleFlag),
    .forceOnes(forceOnes), .forceAis(forceAis), .autoOnesEn(autoOnesEn),
    .e3Mode(e3Mode), .ovhMarkMode(ovhMarkMode),
    .outData(outData), .outMark(outMark)
  );

  function automatic logic faultNow();
    return losFlag | oofFlag | aisFlag | (idleFlag & ~e3Mode);
  endfunction

  function automatic logic modelData(int pos);
    logic aisBit;
    aisBit = (pos % 2 == 0);
    if (forceOnes) return 1'b1;
    if (forceAis) return aisBit;
    if (autoOnesEn && faultNow()) return 1'b1;
    return rxData;
  endfunction

  function automatic string dataTag();
    if (forceOnes && forceAis) return "R6";
    if (forceOnes) return "R4";
    if (forceAis) return (autoOnesEn && faultNow()) ? "R10" : "R5";
    if (autoOnesEn && faultNow()) return e3Mode ? "R8" : "R7";
    if (autoOnesEn && e3Mode && idleFlag) return "R8";
    if (losFlag | oofFlag | aisFlag | idleFlag) return "R9";
    return "R3";
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs already set at the falling edge; advance one clock and compare
  task automatic step();
    string dTag;
    string mTag;
    dTag = bitEn ? dataTag() : "R2";
    mTag = bitEn ? (ovhMarkMode ? "R11" : "R12") : "R2";
    if (bitEn) begin
      expData = modelData(frameStart ? 0 : bitPos);
      expMark = ovhMarkMode ? ovhBit : frameStart;
      bitPos  = frameStart ? 1 : bitPos + 1;
    end
    @(posedge clk);
    #1;
    check(dTag, outData, expData, "outData");
    check(mTag, outMark, expMark, "outMark");
    @(negedge clk);
  endtask

  task automatic clearAll();
    {bitEn, rxData, frameStart, ovhBit} = '0;
    {losFlag, oofFlag, aisFlag, idleFlag} = '0;
    {forceOnes, forceAis, autoOnesEn, e3Mode, ovhMarkMode} = '0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    bitEn = 1; rxData = 1; frameStart = 1; ovhBit = 1; forceOnes = 1;
    @(negedge clk);
    // R1: reset holds outputs low despite active inputs
    check("R1", outData, 1'b0, "outData in reset");
    check("R1", outMark, 1'b0, "outMark in reset");
    clearAll();
    rstN = 1'b1;
    #1;
    check("R1", outData, 1'b0, "outData after reset");
    check("R1", outMark, 1'b0, "outMark after reset");

    // R3 directed: plain pass-through, marker on frame starts (R12)
    for (int i = 0; i < 16; i++) begin
      bitEn = 1; rxData = i[0] ^ i[2]; frameStart = (i == 3); ovhBit = (i % 5 == 0);
      step();
    end

    // R2 directed: hold while bitEn low, inputs toggling
    for (int i = 0; i < 6; i++) begin
      bitEn = 0; rxData = i[0]; frameStart = ~i[0]; ovhBit = i[0]; forceOnes = i[1];
      step();
    end
    forceOnes = 0;

    // R5 directed: AIS pattern restarts on a frame start that lands mid-pattern
    forceAis = 1; e3Mode = 1;
    for (int i = 0; i < 14; i++) begin
      bitEn = 1; rxData = 0; frameStart = (i == 0) || (i == 5) || (i == 8);
      ovhBit = frameStart; ovhMarkMode = 1;
      step();
    end
    forceAis = 0; e3Mode = 0;

    // R9 directed: auto ones ends on the first clear bit
    autoOnesEn = 1;
    for (int i = 0; i < 10; i++) begin
      bitEn = 1; rxData = 0; frameStart = 0;
      losFlag = (i >= 2 && i < 5); oofFlag = (i == 4);
      step();
    end
    // R8 directed: E3 ignores idle alone
    e3Mode = 1; losFlag = 0; oofFlag = 0; idleFlag = 1;
    for (int i = 0; i < 6; i++) begin
      bitEn = 1; rxData = i[0];
      step();
    end
    // R7 directed: DS3 idle triggers
    e3Mode = 0;
    for (int i = 0; i < 4; i++) begin
      bitEn = 1; rxData = 0;
      step();
    end
    clearAll();

    // constrained random blocks
    for (int blk = 0; blk < 24; blk++) begin
      int sc;
      sc = blk % 6;
      for (int i = 0; i < 150; i++) begin
        bitEn       = ($urandom % 6) != 0;
        rxData      = $urandom % 2;
        frameStart  = ($urandom % 14) == 0;
        ovhBit      = frameStart | (($urandom % 9) == 0);
        losFlag     = ($urandom % 7) == 0;
        oofFlag     = ($urandom % 7) == 0;
        aisFlag     = ($urandom % 7) == 0;
        idleFlag    = ($urandom % 4) == 0;
        e3Mode      = (blk / 6) % 2;
        ovhMarkMode = (blk / 3) % 2;
        forceOnes   = (sc == 1 || sc == 5) ? (($urandom % 2) == 0) : 1'b0;
        forceAis    = (sc == 2 || sc == 5) ? (($urandom % 8) != 0) : 1'b0;
        autoOnesEn  = (sc == 3 || sc == 4 || sc == 2) ? (($urandom % 8) != 0) : 1'b0;
        step();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule